// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit IEEE 754 binary32 values and returns a binary32 sum with an overflow flag and an underflow flag. A subtract request inverts the sign of the second operand. The datapath then adds the two signed significands. It unpacks each operand and restores the hidden bit. The larger-magnitude operand sets the tentative exponent, and the smaller significand is shifted right to line up with it. Every bit shifted out is kept in a sticky bit. The signed sum is normalized in either direction and rounded to nearest with ties to even, using a guard bit, a round bit and the sticky bit. The result is then packed.

Zero, infinity and NaN inputs each take their own path. Operands with a zero exponent field are treated as zero, keeping their sign. Results too small for a normal exponent are flushed to a signed zero. The block has one operation stage. With the `REG_OUT` parameter at its default of 1, a request accepted on `in_valid` produces its result and `out_valid` one clock later. Setting `REG_OUT` to 0 gives a purely combinational variant.

Top module: `fpa_addsub`

## Requirements
- R1: Encodings are read as follows. An operand whose exponent field (bits 30:23) is 0 is treated as a zero of its own sign, whatever its fraction. Exponent 255 with a zero fraction is infinity. Exponent 255 with a nonzero fraction is NaN. Exponents 1 to 254 are normal numbers.
- R2: With `sub_op` = 1 the result is `opa` minus `opb`, computed by inverting the sign bit (bit 31) of `opb` and then adding.
- R3: When both operands have the same sign and their exponents differ by more than 24, the result is the larger operand unchanged.
- R4: A sum that carries into a second integer bit is shifted right once and its exponent incremented, so 1.0 + 1.0 (0x3F800000 twice) gives 0x40000000.
- R5: Operands of equal magnitude and opposite effective sign produce +0 (0x00000000) with both flags low.
- R6: Finite results are rounded to nearest, with an exact half rounded to the even significand. Bits lost in alignment count through a sticky bit, so a value just above half rounds up.
- R7: A rounded exponent of 255 or more returns infinity with the result sign and sets `ovf_flag`.
- R8: A nonzero exact result whose rounded exponent is 0 or less returns a zero with the result sign and sets `unf_flag`.
- R9: A NaN operand, or infinities of opposite effective sign, returns 0x7FC00000 with both flags low.
- R10: An infinity operand combined with a finite operand returns that infinity with its effective sign and both flags low.
- R11: With `REG_OUT` = 1, `out_valid` is high exactly one cycle after `in_valid`. Result and flags update only for accepted requests and hold otherwise. Reset clears all outputs to 0.
- R12: Two zero operands with the same effective sign return a zero of that sign. Zeros of opposite effective sign return +0.
- R13: At most one flag is high, and both flags are low for every in-range finite result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; operands and `sub_op` are sampled when high |
| sub_op | input | 1 | 1 = subtract `opb` from `opa`, 0 = add |
| opa | input | 32 | First operand, binary32 |
| opb | input | 32 | Second operand, binary32 |
| out_valid | output | 1 | Result is new this cycle |
| result | output | 32 | Rounded binary32 result |
| ovf_flag | output | 1 | Exponent overflow, result is infinity |
| unf_flag | output | 1 | Exponent underflow, result flushed to zero |

## Verification
Every result, flag and `out_valid` value is due on the clock edge after the edge that sampled `in_valid`, because a single output register follows the combinational datapath. The bench drives a request on a falling edge and drops `in_valid` on the next falling edge. It compares all outputs at that same point, which lies half a period after the register loads. The hold behaviour is checked one further cycle later: a changed operand is presented with `in_valid` low, and the bench confirms that nothing at the outputs moved.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

   // Operand category after decoding the exponent and fraction fields.
   typedef enum logic [1:0] {
      CLS_ZERO = 2'd0,
      CLS_NORM = 2'd1,
      CLS_INF  = 2'd2,
      CLS_NAN  = 2'd3
   } fp_class_e;

   // Extra bits carried below the significand: guard, round, sticky.
   localparam int unsigned GRS_W = 3;

endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
   import fpa_pkg::*;
#(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
   localparam int unsigned SIG_W  = FRAC_W + 1
) (
   input  logic [WORD_W-1:0] word,
   input  logic              flip,
   output logic              sign,
   output logic [EXP_W-1:0]  exp,
   output logic [SIG_W-1:0]  sig,
   output fp_class_e         cls
);

   logic [EXP_W-1:0]  raw_exp;
   logic [FRAC_W-1:0] raw_frac;
   logic              exp_zero, exp_ones;

   assign raw_exp  = word[WORD_W-2 -: EXP_W];
   assign raw_frac = word[FRAC_W-1:0];
   assign exp_zero = (raw_exp == '0);
   assign exp_ones = (raw_exp == '1);
   assign sign     = word[WORD_W-1] ^ flip;

   always_comb begin
      exp = raw_exp;
      sig = {1'b1, raw_frac};
      if (exp_zero) begin
         // denormals are read as zero of their own sign (R1)
         cls = CLS_ZERO;
         exp = '0;
         sig = '0;
      end else if (exp_ones) begin
         cls = (raw_frac == '0) ? CLS_INF : CLS_NAN;
      end else begin
         cls = CLS_NORM;
      end
   end

   always_comb begin
      if (cls == CLS_ZERO) a_r1_zero_empty: assert (sig == '0);
   end

endmodule

// File: rtl/fpa_align.sv
module fpa_align
   import fpa_pkg::*;
#(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned SIG_W = 24,
   localparam int unsigned EXT_W = SIG_W + GRS_W
) (
   input  logic              a_sign,
   input  logic [EXP_W-1:0]  a_exp,
   input  logic [SIG_W-1:0]  a_sig,
   input  logic              b_sign,
   input  logic [EXP_W-1:0]  b_exp,
   input  logic [SIG_W-1:0]  b_sig,
   output logic              big_sign,
   output logic [EXP_W-1:0]  big_exp,
   output logic [SIG_W-1:0]  big_sig,
   output logic              small_sign,
   output logic [EXT_W-1:0]  small_aln
);

   if (SIG_W < 4) begin : g_bad_sig
      $error("fpa_align: SIG_W must be at least 4");
   end

   logic              swap;
   logic [EXP_W-1:0]  small_exp, diff;
   logic [SIG_W-1:0]  small_sig;
   logic [EXT_W-1:0]  small_ext, shifted, lost;
   logic              sticky;

   // Order by magnitude so the subtraction below never goes negative.
   assign swap = {b_exp, b_sig} > {a_exp, a_sig};

   always_comb begin
      big_sign   = swap ? b_sign : a_sign;
      big_exp    = swap ? b_exp  : a_exp;
      big_sig    = swap ? b_sig  : a_sig;
      small_sign = swap ? a_sign : b_sign;
      small_exp  = swap ? a_exp  : b_exp;
      small_sig  = swap ? a_sig  : b_sig;
   end

   assign diff      = big_exp - small_exp;
   assign small_ext = {small_sig, {GRS_W{1'b0}}};

   always_comb begin
      if (32'(diff) >= EXT_W) begin
         // everything leaves the window: only the sticky bit survives (R3)
         shifted = '0;
         lost    = small_ext;
      end else begin
         shifted = small_ext >> diff;
         lost    = small_ext & ~({EXT_W{1'b1}} << diff);
      end
      sticky    = |lost;
      small_aln = {shifted[EXT_W-1:1], shifted[0] | sticky};
   end

   always_comb begin
      a_r3_small_not_larger: assert (small_aln <= {big_sig, {GRS_W{1'b0}}});
   end

endmodule

// File: rtl/fpa_addnorm.sv
module fpa_addnorm
   import fpa_pkg::*;
#(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned SIG_W = 24,
   localparam int unsigned EXT_W = SIG_W + GRS_W,
   localparam int unsigned LZ_W  = $clog2(EXT_W + 1),
   localparam int unsigned EW2   = EXP_W + 2
) (
   input  logic                  big_sign,
   input  logic [EXP_W-1:0]      big_exp,
   input  logic [SIG_W-1:0]      big_sig,
   input  logic                  small_sign,
   input  logic [EXT_W-1:0]      small_aln,
   output logic                  res_sign,
   output logic signed [EW2-1:0] res_exp,
   output logic [EXT_W-1:0]      norm,
   output logic                  sum_zero
);

   if (EW2 <= LZ_W) begin : g_bad_exp
      $error("fpa_addnorm: exponent too narrow for the shift count");
   end

   logic              eff_sub;
   logic [EXT_W:0]    big_ext, sum;
   logic [LZ_W-1:0]   lz;
   logic              found;
   logic signed [EW2-1:0] base_exp;

   assign eff_sub  = big_sign ^ small_sign;
   assign big_ext  = {1'b0, big_sig, {GRS_W{1'b0}}};
   assign sum      = eff_sub ? (big_ext - {1'b0, small_aln})
                             : (big_ext + {1'b0, small_aln});
   assign sum_zero = (sum == '0);
   assign res_sign = big_sign;
   assign base_exp = $signed({2'b00, big_exp});

   // leading-zero count over the non-carry part of the sum
   always_comb begin
      lz    = '0;
      found = 1'b0;
      for (int i = EXT_W - 1; i >= 0; i--) begin
         if (!found && sum[i]) begin
            lz    = LZ_W'(EXT_W - 1 - i);
            found = 1'b1;
         end
      end
   end

   always_comb begin
      if (sum[EXT_W]) begin
         // carry into a second integer bit: one right shift, keep sticky (R4)
         norm    = {sum[EXT_W:2], sum[1] | sum[0]};
         res_exp = base_exp + EW2'(1);
      end else begin
         // cancellation can need a shift across the whole width (R5)
         norm    = sum[EXT_W-1:0] << lz;
         res_exp = base_exp - $signed({{(EW2-LZ_W){1'b0}}, lz});
      end
   end

   always_comb begin
      if (!sum_zero) a_r4_leading_one: assert (norm[EXT_W-1]);
   end

endmodule

// File: rtl/fpa_round.sv
module fpa_round
   import fpa_pkg::*;
#(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned SIG_W  = FRAC_W + 1,
   localparam int unsigned EXT_W  = SIG_W + GRS_W,
   localparam int unsigned EW2    = EXP_W + 2,
   localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic                  res_sign,
   input  logic signed [EW2-1:0] res_exp,
   input  logic [EXT_W-1:0]      norm,
   input  logic                  sum_zero,
   input  logic                  zero_sign,
   output logic [WORD_W-1:0]     word,
   output logic                  ovf,
   output logic                  unf
);

   localparam logic signed [EW2-1:0] EXP_TOP = EW2'((1 << EXP_W) - 1);

   logic [SIG_W-1:0]       mant, mant_f;
   logic                   g_bit, r_bit, s_bit, round_up;
   logic [SIG_W:0]         rnd;
   logic signed [EW2-1:0]  exp_f;

   assign mant     = norm[EXT_W-1:GRS_W];
   assign g_bit    = norm[2];
   assign r_bit    = norm[1];
   assign s_bit    = norm[0];
   // nearest, ties to even (R6)
   assign round_up = g_bit & (r_bit | s_bit | mant[0]);
   assign rnd      = {1'b0, mant} + (SIG_W + 1)'(round_up);

   always_comb begin
      if (rnd[SIG_W]) begin
         mant_f = rnd[SIG_W:1];
         exp_f  = res_exp + EW2'(1);
      end else begin
         mant_f = rnd[SIG_W-1:0];
         exp_f  = res_exp;
      end
   end

   always_comb begin
      ovf  = 1'b0;
      unf  = 1'b0;
      word = {res_sign, exp_f[EXP_W-1:0], mant_f[FRAC_W-1:0]};
      if (sum_zero) begin
         word = {zero_sign, {(WORD_W-1){1'b0}}};
      end else if (exp_f >= EXP_TOP) begin
         ovf  = 1'b1;
         word = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (exp_f <= EW2'(0)) begin
         unf  = 1'b1;
         word = {res_sign, {(WORD_W-1){1'b0}}};
      end
   end

   always_comb begin
      a_r13_one_flag: assert (!(ovf && unf));
   end

endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub
   import fpa_pkg::*;
#(
   parameter int unsigned EXP_W   = 8,
   parameter int unsigned FRAC_W  = 23,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    sub_op,
   input  logic [EXP_W+FRAC_W:0]   opa,
   input  logic [EXP_W+FRAC_W:0]   opb,
   output logic                    out_valid,
   output logic [EXP_W+FRAC_W:0]   result,
   output logic                    ovf_flag,
   output logic                    unf_flag
);

   localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
   localparam int unsigned SIG_W  = FRAC_W + 1;
   localparam int unsigned EXT_W  = SIG_W + GRS_W;
   localparam int unsigned EW2    = EXP_W + 2;
   localparam logic [WORD_W-1:0] QNAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   if (EXP_W < 4 || FRAC_W < 4) begin : g_bad_fmt
      $error("fpa_addsub: EXP_W and FRAC_W must each be at least 4");
   end

   // ---------------- operand decode ----------------
   logic [WORD_W-1:0] op_word [2];
   logic [1:0]        op_flip;
   logic [1:0]        u_sign;
   logic [EXP_W-1:0]  u_exp [2];
   logic [SIG_W-1:0]  u_sig [2];
   fp_class_e         u_cls [2];

   assign op_word[0] = opa;
   assign op_word[1] = opb;
   assign op_flip    = {sub_op, 1'b0};   // R2: subtract flips the second sign

   for (genvar k = 0; k < 2; k++) begin : g_unpack
      fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) unpack_i (
         .word (op_word[k]),
         .flip (op_flip[k]),
         .sign (u_sign[k]),
         .exp  (u_exp[k]),
         .sig  (u_sig[k]),
         .cls  (u_cls[k])
      );
   end

   // ---------------- arithmetic path ----------------
   logic                  big_sign, small_sign, res_sign, sum_zero;
   logic [EXP_W-1:0]      big_exp;
   logic [SIG_W-1:0]      big_sig;
   logic [EXT_W-1:0]      small_aln, norm;
   logic signed [EW2-1:0] res_exp;
   logic [WORD_W-1:0]     arith_word;
   logic                  arith_ovf, arith_unf;

   fpa_align #(.EXP_W(EXP_W), .SIG_W(SIG_W)) align_i (
      .a_sign     (u_sign[0]),
      .a_exp      (u_exp[0]),
      .a_sig      (u_sig[0]),
      .b_sign     (u_sign[1]),
      .b_exp      (u_exp[1]),
      .b_sig      (u_sig[1]),
      .big_sign   (big_sign),
      .big_exp    (big_exp),
      .big_sig    (big_sig),
      .small_sign (small_sign),
      .small_aln  (small_aln)
   );

   fpa_addnorm #(.EXP_W(EXP_W), .SIG_W(SIG_W)) addnorm_i (
      .big_sign   (big_sign),
      .big_exp    (big_exp),
      .big_sig    (big_sig),
      .small_sign (small_sign),
      .small_aln  (small_aln),
      .res_sign   (res_sign),
      .res_exp    (res_exp),
      .norm       (norm),
      .sum_zero   (sum_zero)
   );

   fpa_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) round_i (
      .res_sign  (res_sign),
      .res_exp   (res_exp),
      .norm      (norm),
      .sum_zero  (sum_zero),
      .zero_sign (u_sign[0] & u_sign[1]),   // R5, R12
      .word      (arith_word),
      .ovf       (arith_ovf),
      .unf       (arith_unf)
   );

   // ---------------- special operands ----------------
   logic              is_nan_case;
   logic [WORD_W-1:0] next_word;
   logic              next_ovf, next_unf;

   assign is_nan_case = (u_cls[0] == CLS_NAN) || (u_cls[1] == CLS_NAN) ||
                        ((u_cls[0] == CLS_INF) && (u_cls[1] == CLS_INF) &&
                         (u_sign[0] != u_sign[1]));

   always_comb begin
      next_word = arith_word;
      next_ovf  = arith_ovf;
      next_unf  = arith_unf;
      if (is_nan_case) begin
         next_word = QNAN;
         next_ovf  = 1'b0;
         next_unf  = 1'b0;
      end else if (u_cls[0] == CLS_INF || u_cls[1] == CLS_INF) begin
         next_word = {(u_cls[0] == CLS_INF) ? u_sign[0] : u_sign[1],
                      {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         next_ovf  = 1'b0;
         next_unf  = 1'b0;
      end
   end

   // ---------------- output stage ----------------
   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf_flag  <= 1'b0;
            unf_flag  <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               result   <= next_word;
               ovf_flag <= next_ovf;
               unf_flag <= next_unf;
            end
         end
      end

      a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      a_r11_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(result) && $stable(ovf_flag) && $stable(unf_flag));
   end else begin : g_comb_out
      assign out_valid = in_valid;
      assign result    = next_word;
      assign ovf_flag  = next_ovf;
      assign unf_flag  = next_unf;
   end

   a_r7_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
   a_r8_unf_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
      unf_flag |-> (result[WORD_W-2:0] == '0));
   a_r9_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (result[WORD_W-2 -: EXP_W] == '1 && result[FRAC_W-1:0] != '0)
         |-> (result == QNAN && !ovf_flag && !unf_flag));
   a_r13_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_flag && unf_flag));

endmodule

// File: tb/fpa_addsub_tb.sv
module fpa_addsub_tb_top;

   localparam int WD_CYCLES = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        sub_op = 1'b0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic        out_valid;
   logic [31:0] result;
   logic        ovf_flag, unf_flag;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   fpa_addsub dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .sub_op    (sub_op),
      .opa       (opa),
      .opb       (opb),
      .out_valid (out_valid),
      .result    (result),
      .ovf_flag  (ovf_flag),
      .unf_flag  (unf_flag)
   );

   // exact conversion of a finite binary32 (denormals read as zero) to real
   function automatic real to_real(input logic [31:0] w);
      logic [63:0] d;
      if (w[30:23] == 8'd0) d = {w[31], 63'd0};
      else d = {w[31], 11'(int'(w[30:23]) - 127 + 1023), w[22:0], 29'd0};
      return $bitstoreal(d);
   endfunction

   // reference: {ovf, unf, word}
   function automatic logic [33:0] ref_model(input logic [31:0] a,
                                             input logic [31:0] b,
                                             input logic sub);
      logic [31:0] bb;
      logic        a_nan, b_nan, a_inf, b_inf;
      real         r;
      logic [63:0] d;
      logic [52:0] m;
      logic [24:0] mm;
      logic [28:0] rest;
      logic        up;
      int          be;
      bb    = {b[31] ^ sub, b[30:0]};
      a_nan = (a[30:23] == 8'hFF) && (a[22:0] != 0);
      b_nan = (bb[30:23] == 8'hFF) && (bb[22:0] != 0);
      a_inf = (a[30:23] == 8'hFF) && (a[22:0] == 0);
      b_inf = (bb[30:23] == 8'hFF) && (bb[22:0] == 0);
      if (a_nan || b_nan || (a_inf && b_inf && a[31] != bb[31]))
         return {2'b00, 32'h7FC00000};
      if (a_inf) return {2'b00, a};
      if (b_inf) return {2'b00, bb};
      r = to_real(a) + to_real(bb);
      d = $realtobits(r);
      if (d[62:0] == 0) return {2'b00, d[63], 31'd0};
      m    = {1'b1, d[51:0]};
      rest = m[28:0];
      up   = (rest > 29'h10000000) || (rest == 29'h10000000 && m[29]);
      mm   = {1'b0, m[52:29]} + 25'(up);
      be   = int'(d[62:52]) - 1023 + 127;
      if (mm[24]) begin
         mm = mm >> 1;
         be = be + 1;
      end
      if (be >= 255) return {2'b10, d[63], 8'hFF, 23'd0};
      if (be <= 0)   return {2'b01, d[63], 31'd0};
      return {2'b00, d[63], 8'(be), mm[22:0]};
   endfunction

   task automatic run_vec(input string req, input logic [31:0] a,
                          input logic [31:0] b, input logic sub);
      logic [33:0] expv;
      expv = ref_model(a, b, sub);
      @(negedge clk);
      opa = a; opb = b; sub_op = sub; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      n_checks++;
      if (!out_valid || {ovf_flag, unf_flag, result} !== expv) begin
         n_errors++;
         $display("FAIL %s a=%h b=%h sub=%0b actual v=%0b ovf=%0b unf=%0b res=%h expected v=1 ovf=%0b unf=%0b res=%h",
                  req, a, b, sub, out_valid, ovf_flag, unf_flag, result,
                  expv[33], expv[32], expv[31:0]);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      #(WD_CYCLES * 20);
      n_checks++;
      n_errors++;
      $display("FAIL R11 watchdog actual=hung expected=complete");
      summary();
   end

   initial begin
      logic [31:0] held;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11: reset state
      n_checks++;
      if (out_valid !== 1'b0 || result !== 32'd0 || ovf_flag !== 1'b0 || unf_flag !== 1'b0) begin
         n_errors++;
         $display("FAIL R11 reset actual v=%0b res=%h ovf=%0b unf=%0b expected all zero",
                  out_valid, result, ovf_flag, unf_flag);
      end
      rst_n = 1'b1;
      @(negedge clk);

      run_vec("R1",  32'h00400000, 32'h3F800000, 1'b0);  // denormal reads as zero
      run_vec("R1",  32'h80000001, 32'h80000000, 1'b0);
      run_vec("R2",  32'h40400000, 32'h3F800000, 1'b1);  // 3 - 1
      run_vec("R2",  32'h3F800000, 32'hC0000000, 1'b1);  // 1 - (-2)
      run_vec("R3",  32'h4E800000, 32'h3F800000, 1'b0);  // diff 30
      run_vec("R3",  32'h3F800000, 32'h32800000, 1'b0);  // diff 26
      run_vec("R3",  32'h3F800000, 32'h00800000, 1'b1);  // shift-out in subtract
      run_vec("R4",  32'h3F800000, 32'h3F800000, 1'b0);
      run_vec("R4",  32'h3FFFFFFF, 32'h3FFFFFFF, 1'b0);
      run_vec("R5",  32'h3FC00000, 32'h3FC00000, 1'b1);
      run_vec("R5",  32'hC1234567, 32'h41234567, 1'b0);
      run_vec("R5",  32'h3F800001, 32'h3F800000, 1'b1);  // deep cancellation
      run_vec("R6",  32'h3F800000, 32'h33800000, 1'b0);  // tie, even stays
      run_vec("R6",  32'h3F800001, 32'h33800000, 1'b0);  // tie, odd rounds up
      run_vec("R6",  32'h3F800000, 32'h33800001, 1'b0);  // sticky above half
      run_vec("R7",  32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0);
      run_vec("R7",  32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1);
      run_vec("R8",  32'h00800000, 32'h00800001, 1'b1);
      run_vec("R8",  32'h00C00000, 32'h80A00000, 1'b0);
      run_vec("R9",  32'h7FC00001, 32'h3F800000, 1'b0);
      run_vec("R9",  32'h7F800000, 32'h7F800000, 1'b1);
      run_vec("R9",  32'hFF800000, 32'h7F800000, 1'b0);
      run_vec("R9",  32'h3F800000, 32'hFF800001, 1'b1);
      run_vec("R10", 32'h7F800000, 32'h3F800000, 1'b0);
      run_vec("R10", 32'h3F800000, 32'h7F800000, 1'b1);
      run_vec("R12", 32'h80000000, 32'h80000000, 1'b0);
      run_vec("R12", 32'h00000000, 32'h80000000, 1'b0);
      run_vec("R12", 32'h80000000, 32'h00000000, 1'b1);
      run_vec("R13", 32'h3FC00000, 32'h3FC00000, 1'b0);

      // R11: outputs hold while in_valid is low
      held = result;
      @(negedge clk);
      opa = 32'h40000000; opb = 32'h40000000; sub_op = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || result !== held || ovf_flag !== 1'b0 || unf_flag !== 1'b0) begin
         n_errors++;
         $display("FAIL R11 hold actual v=%0b res=%h expected v=0 res=%h",
                  out_valid, result, held);
      end

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] a, b;
         int          kind;
         logic        s;
         a    = $urandom;
         kind = int'($urandom % 8);
         s    = 1'($urandom);
         if (kind < 5) begin
            b = {1'($urandom), 8'(a[30:23] + 8'(($urandom % 7) - 3)), 23'($urandom)};
         end else begin
            b = $urandom;
         end
         if (kind == 7) a[30:23] = 8'hFF;
         if (kind == 6) b[30:23] = 8'($urandom % 3);
         run_vec(s ? "R2" : "R6", a, b, s);
      end

      summary();
   end

endmodule